// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

A 32-bit processor core that completes one instruction per clock edge. It executes eight instructions: five register-to-register ALU operations, a word load, a word store and a branch on equality. Instruction and data storage are separate memories, both inside the core. The instruction memory is read-only from the core's side. Every control signal comes from a combinational decoder that looks at the opcode, the function field and the ALU zero flag.

The core comes out of an asynchronous active-low reset through a two-stage synchronizer. While the core is held in reset, a load port fills either memory one word per clock. A third read port on the register file lets the surrounding logic observe architectural state without stopping the core.

Top module: `sc_core`

## Requirements
- R1: While reset is low, and for two rising edges after it is released, no instruction takes effect. The first instruction executed is the one at word 0, and its result is visible after the third rising edge.
- R2: Opcode 000000 with func[5:0] equal to 100000 (add), 100010 (sub), 100100 (and), 100101 (or) or 101010 (set-on-less-than) writes the result of rs[25:21] op rt[20:16] into rd[15:11]. The less-than compare is signed and gives 1 or 0.
- R3: Opcode 100011 writes register rt with the data word whose index is bits [7:2] of rs + sign-extended imm[15:0]. The index wraps modulo 64.
- R4: Opcode 101011 writes register rt into the data word addressed as in R3 and writes no register. A later load returns the stored word.
- R5: Opcode 000100 compares rs with rt. If they are equal, the next PC is PC+4 + (sign-extended imm << 2); otherwise it is PC+4. An offset of -1 holds the PC on the branch.
- R6: Register 0 always reads as zero, and writes to it are discarded.
- R7: Any other opcode, or opcode 000000 with any other func, writes neither a register nor memory, and execution continues at PC+4.
- R8: Every instruction takes exactly one cycle. Its result is visible after the rising edge that ends its cycle, and not before.
- R9: dbg_data shows, combinationally, the register selected by dbg_addr.
- R10: On a rising edge with load_en high, load_data is written at word load_addr: into the data memory if load_dmem is 1, otherwise into the instruction memory.
- R11: For any program built from these instructions, the register file after N executed cycles equals the result of running N instructions in order from word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| load_en | input | 1 | Write one memory word this cycle |
| load_dmem | input | 1 | 1 selects the data memory, 0 the instruction memory |
| load_addr | input | MEM_AW | Word index for the load |
| load_data | input | W | Word to load |
| dbg_addr | input | RF_AW | Register selected for observation |
| dbg_data | output | W | Contents of the selected register |

## Verification
After rst_n rises, two edges pass in the synchronizer. The instruction at word 0 then lands on the third edge, and each later instruction on one further edge. The bench releases reset on a falling edge, counts rising edges from there, and reads the debug port just after the following falling edge. At that point the expected number of instructions has retired and the next has not. Only the reset-timing check depends on this exact count. Every other program ends in a branch-to-self, so the extra edges spent reading the registers leave state unchanged, and a sequential reference model in the bench runs the same number of steps.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic    dst_rd;   // write address from rd (1) or rt (0)
    logic    reg_we;
    logic    src_imm;  // second ALU operand is the immediate
    logic    mem_we;
    logic    mem_rd;
    logic    wb_mem;   // write-back from data memory
    logic    branch;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic       alu_zero,
  output ctrl_t      ctrl,
  output logic       pc_src
);

  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_ADD;
    case (opcode)
      OP_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        case (funct)
          FN_ADD: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_ADD; end
          FN_SUB: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SUB; end
          FN_AND: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_AND; end
          FN_OR:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_OR;  end
          FN_SLT: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SLT; end
          default: ;
        endcase
      end
      OP_LOAD: begin
        ctrl.src_imm = 1'b1;
        ctrl.reg_we  = 1'b1;
        ctrl.mem_rd  = 1'b1;
        ctrl.wb_mem  = 1'b1;
      end
      OP_STORE: begin
        ctrl.src_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      default: ;
    endcase
  end

  assign pc_src = ctrl.branch & alu_zero;

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  input  logic [AW-1:0] ra_dbg,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  output logic [W-1:0]  rd_dbg
);
  localparam int NREG = 1 << AW;

  logic [W-1:0] regs [NREG];
  logic         wr_en;

  assign wr_en = we && (waddr != '0);

  always_ff @(posedge clk) begin
    if (wr_en) regs[waddr] <= wdata;
  end

  assign rd_a   = (ra_a   == '0) ? '0 : regs[ra_a];
  assign rd_b   = (ra_b   == '0) ? '0 : regs[ra_b];
  assign rd_dbg = (ra_dbg == '0) ? '0 : regs[ra_dbg];

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int W      = 32,
  parameter int MEM_AW = 6,
  parameter int RF_AW  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              load_dmem,
  input  logic [MEM_AW-1:0] load_addr,
  input  logic [W-1:0]      load_data,
  input  logic [RF_AW-1:0]  dbg_addr,
  output logic [W-1:0]      dbg_data
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int IMM_W = 16;
  localparam int IX_LO = 2;
  localparam int IX_HI = MEM_AW + 1;

  // reset: asserted asynchronously, released after two edges
  logic [1:0] rst_pipe;
  logic       run_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign run_n = rst_pipe[1];

  // program counter
  logic [W-1:0] pc_q, pc_d, pc_plus4, pc_tgt;

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // instruction memory
  logic [W-1:0] imem [DEPTH];
  logic         imem_we;
  logic [W-1:0] instr;

  assign imem_we = load_en & ~load_dmem;
  always_ff @(posedge clk) begin
    if (imem_we) imem[load_addr] <= load_data;
  end
  assign instr = imem[pc_q[IX_HI:IX_LO]];

  // fields
  logic [5:0]       f_op, f_fn;
  logic [RF_AW-1:0] f_rs, f_rt, f_rd;
  logic [W-1:0]     imm_x;

  assign f_op  = instr[31:26];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_fn  = instr[5:0];
  assign imm_x = {{(W-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};

  // control
  ctrl_t ctrl;
  logic  alu_zero, pc_src;

  sc_decode u_dec (
    .opcode   (f_op),
    .funct    (f_fn),
    .alu_zero (alu_zero),
    .ctrl     (ctrl),
    .pc_src   (pc_src)
  );

  // register file and ALU
  logic [W-1:0]     rd_a, rd_b, alu_b, alu_y, wb_data, dmem_q;
  logic [RF_AW-1:0] wr_addr;
  logic             reg_we_g, mem_we_g;

  assign reg_we_g = ctrl.reg_we & run_n;
  assign mem_we_g = ctrl.mem_we & run_n;
  assign wr_addr  = ctrl.dst_rd  ? f_rd   : f_rt;
  assign alu_b    = ctrl.src_imm ? imm_x  : rd_b;
  assign wb_data  = ctrl.wb_mem  ? dmem_q : alu_y;

  sc_regfile #(.W(W), .AW(RF_AW)) u_rf (
    .clk    (clk),
    .we     (reg_we_g),
    .waddr  (wr_addr),
    .wdata  (wb_data),
    .ra_a   (f_rs),
    .ra_b   (f_rt),
    .ra_dbg (dbg_addr),
    .rd_a   (rd_a),
    .rd_b   (rd_b),
    .rd_dbg (dbg_data)
  );

  sc_alu #(.W(W)) u_alu (
    .a    (rd_a),
    .b    (alu_b),
    .op   (ctrl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data memory: the load port has priority over the core
  logic [W-1:0] dmem [DEPTH];
  logic         dmem_ld;

  assign dmem_ld = load_en & load_dmem;
  always_ff @(posedge clk) begin
    if (dmem_ld)       dmem[load_addr]          <= load_data;
    else if (mem_we_g) dmem[alu_y[IX_HI:IX_LO]] <= rd_b;
  end
  assign dmem_q = dmem[alu_y[IX_HI:IX_LO]];

  // next PC
  assign pc_plus4 = pc_q + W'(4);
  assign pc_tgt   = pc_plus4 + (imm_x << 2);
  assign pc_d     = pc_src ? pc_tgt : pc_plus4;

  logic unused_bits;
  assign unused_bits = ^{pc_q[W-1:IX_HI+1], pc_q[1:0], alu_y[W-1:IX_HI+1],
                         alu_y[1:0], instr[10:6], ctrl.mem_rd};

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  pc,
  input logic [W-1:0]  instr,
  input logic          pc_src,
  input logic          reg_we,
  input logic          mem_we,
  input logic [AW-1:0] dbg_addr,
  input logic [W-1:0]  dbg_data
);
  logic live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  logic [5:0]   op, fn;
  logic         known_op, known_fn, quiet;
  logic [W-1:0] br_off;

  assign op       = instr[31:26];
  assign fn       = instr[5:0];
  assign known_op = (op == 6'b000000) || (op == 6'b100011) ||
                    (op == 6'b101011) || (op == 6'b000100);
  assign known_fn = (fn == 6'b100000) || (fn == 6'b100010) ||
                    (fn == 6'b100100) || (fn == 6'b100101) || (fn == 6'b101010);
  assign quiet    = !known_op || ((op == 6'b000000) && !known_fn);
  assign br_off   = {{(W-18){instr[15]}}, instr[15:0], 2'b00};

  assert_reset_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> pc == '0);

  assert_pc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !pc_src) |=> pc == $past(pc) + W'(4));

  assert_pc_branch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && pc_src) |=> pc == $past(pc) + W'(4) + $past(br_off));

  assert_branch_only_beq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pc_src |-> op == 6'b000100);

  assert_store_no_regwrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 6'b101011) |-> (mem_we && !reg_we));

  assert_zero_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_addr == '0) |-> (dbg_data == '0));

  assert_undefined_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> (!reg_we && !mem_we));

  logic unused_chk;
  assign unused_chk = ^{instr[25:16]};

endmodule

bind sc_core sc_core_chk #(.W(W), .AW(RF_AW)) u_chk (
  .clk      (clk),
  .rst_n    (run_n),
  .pc       (pc_q),
  .instr    (instr),
  .pc_src   (pc_src),
  .reg_we   (reg_we_g),
  .mem_we   (mem_we_g),
  .dbg_addr (dbg_addr),
  .dbg_data (dbg_data)
);

// File: tb/sim_sc_core.sv
module sim_sc_core;
  logic        clk = 1'b0;
  logic        rst_n, load_en, load_dmem;
  logic [5:0]  load_addr;
  logic [31:0] load_data, dbg_data;
  logic [4:0]  dbg_addr;

  always #4 clk = ~clk;

  sc_core u0 (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_dmem(load_dmem),
    .load_addr(load_addr), .load_data(load_data),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_im [64];
  logic [31:0] m_dm [64];
  logic [31:0] m_rf [32];
  logic [31:0] m_pc;
  logic [31:0] seed = 32'h1234_5678;

  localparam logic [31:0] HALT = {6'b000100, 5'd0, 5'd0, 16'hFFFF};

  function automatic logic [31:0] rins(input logic [5:0] fn, input int rd, input int rs, input int rt);
    return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] iins(input logic [5:0] op, input int rt, input int rs, input logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction
  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return {16'd0, seed[30:15]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rdreg(input int a, output logic [31:0] v);
    dbg_addr = a[4:0];
    #1;
    v = dbg_data;
  endtask

  // sequential reference model, one instruction per call
  task automatic step();
    logic [31:0] ins, a, b, imm, ea, nxt;
    int rs, rt, rd;
    ins = m_im[m_pc[7:2]];
    rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    a = (rs == 0) ? 32'd0 : m_rf[rs];
    b = (rt == 0) ? 32'd0 : m_rf[rt];
    imm = {{16{ins[15]}}, ins[15:0]};
    ea  = a + imm;
    nxt = m_pc + 32'd4;
    case (ins[31:26])
      6'h00: begin
        logic ok; logic [31:0] v;
        ok = 1'b1; v = 32'd0;
        case (ins[5:0])
          6'h20: v = a + b;
          6'h22: v = a - b;
          6'h24: v = a & b;
          6'h25: v = a | b;
          6'h2a: v = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: ok = 1'b0;
        endcase
        if (ok && rd != 0) m_rf[rd] = v;
      end
      6'h23: if (rt != 0) m_rf[rt] = m_dm[ea[7:2]];
      6'h2b: m_dm[ea[7:2]] = b;
      6'h04: if (a == b) nxt = m_pc + 32'd4 + (imm << 2);
      default: ;
    endcase
    m_pc = nxt;
  endtask

  task automatic load_all();
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      load_en = 1'b1; load_dmem = 1'b0; load_addr = i[5:0]; load_data = m_im[i];
    end
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      load_en = 1'b1; load_dmem = 1'b1; load_addr = i[5:0]; load_data = m_dm[i];
    end
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic run(input int n);
    @(negedge clk);
    rst_n = 1'b0;
    load_all();
    m_pc = 32'd0;
    for (int i = 0; i < n; i++) step();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (n + 2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic compare_regs(input string req, input int hi);
    logic [31:0] v;
    for (int r = 0; r <= hi; r++) begin
      rdreg(r, v);
      check(req, v, (r == 0) ? 32'd0 : m_rf[r]);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; load_en = 1'b0; load_dmem = 1'b0;
    load_addr = '0; load_data = '0; dbg_addr = '0;
    for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
    repeat (3) @(posedge clk);

    // Phase A: clear every register with and rX, r0, r0
    for (int i = 0; i < 64; i++) begin
      m_im[i] = (i < 31) ? rins(6'h24, i + 1, 0, 0) : HALT;
      m_dm[i] = 32'd0;
    end
    run(40);
    compare_regs("R2 and-clear", 31);

    // Phase B: directed program
    for (int i = 0; i < 64; i++) begin m_im[i] = HALT; m_dm[i] = 32'd0; end
    m_dm[0] = 32'd7; m_dm[1] = 32'hFFFF_FFFD;
    m_dm[2] = 32'h0F0F_00FF; m_dm[3] = 32'h00FF_0F0F; m_dm[63] = 32'h1234_5678;
    m_im[0]  = iins(6'h23, 1, 0, 16'd0);
    m_im[1]  = iins(6'h23, 2, 0, 16'd4);
    m_im[2]  = iins(6'h23, 3, 0, 16'd8);
    m_im[3]  = iins(6'h23, 4, 0, 16'd12);
    m_im[4]  = rins(6'h20, 5, 1, 2);
    m_im[5]  = rins(6'h22, 6, 1, 2);
    m_im[6]  = rins(6'h24, 7, 3, 4);
    m_im[7]  = rins(6'h25, 8, 3, 4);
    m_im[8]  = rins(6'h2a, 9, 2, 1);
    m_im[9]  = rins(6'h2a, 10, 1, 2);
    m_im[10] = iins(6'h2b, 5, 0, 16'd16);
    m_im[11] = iins(6'h23, 11, 0, 16'd16);
    m_im[12] = iins(6'h23, 12, 11, 16'hFFF8);
    m_im[13] = rins(6'h20, 0, 1, 1);
    m_im[14] = iins(6'h04, 1, 1, 16'd2);
    m_im[15] = rins(6'h20, 14, 1, 1);
    m_im[16] = rins(6'h20, 15, 1, 1);
    m_im[17] = iins(6'h04, 2, 1, 16'd1);
    m_im[18] = rins(6'h20, 16, 1, 1);
    m_im[19] = {6'h3F, 5'd1, 5'd17, 16'h0000};
    m_im[20] = rins(6'h3F, 18, 1, 1);
    m_im[21] = rins(6'h20, 21, 1, 2);
    run(40);
    rdreg(1, v);  check("R10 loaded data word", v, 32'd7);
    rdreg(2, v);  check("R9 debug read", v, 32'hFFFF_FFFD);
    rdreg(5, v);  check("R2 add", v, 32'd4);
    rdreg(6, v);  check("R2 sub", v, 32'd10);
    rdreg(7, v);  check("R2 and", v, 32'h000F_000F);
    rdreg(8, v);  check("R2 or", v, 32'h0FFF_0FFF);
    rdreg(9, v);  check("R2 slt signed true", v, 32'd1);
    rdreg(10, v); check("R2 slt signed false", v, 32'd0);
    rdreg(11, v); check("R4 store then load", v, 32'd4);
    rdreg(12, v); check("R3 negative offset wraps", v, 32'h1234_5678);
    rdreg(0, v);  check("R6 r0 write discarded", v, 32'd0);
    rdreg(14, v); check("R5 taken skips", v, 32'd0);
    rdreg(15, v); check("R5 taken skips", v, 32'd0);
    rdreg(16, v); check("R5 not taken falls through", v, 32'd14);
    rdreg(17, v); check("R7 undefined opcode", v, 32'd0);
    rdreg(18, v); check("R7 undefined func", v, 32'd0);
    rdreg(21, v); check("R7 continues at PC+4", v, 32'd4);
    compare_regs("R11 directed model", 31);

    // Phase C: reset release timing
    for (int i = 0; i < 64; i++) begin m_im[i] = HALT; m_dm[i] = 32'd0; end
    m_dm[0] = 32'h55; m_dm[1] = 32'h66;
    m_im[0] = iins(6'h23, 19, 0, 16'd0);
    m_im[1] = iins(6'h23, 20, 0, 16'd4);
    @(negedge clk);
    rst_n = 1'b0;
    load_all();
    repeat (3) @(negedge clk);
    rdreg(19, v); check("R1 nothing runs in reset", v, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rdreg(19, v); check("R1 held two edges after release", v, 32'd0);
    @(posedge clk); @(negedge clk);
    rdreg(19, v); check("R1 word 0 first", v, 32'h55);
    rdreg(20, v); check("R8 next not yet retired", v, 32'd0);
    @(posedge clk); @(negedge clk);
    rdreg(20, v); check("R8 one cycle later", v, 32'h66);
    m_pc = 32'd0; step(); step();

    // Phase D: generated programs over registers 0..7
    for (int k = 0; k < 12; k++) begin
      for (int i = 0; i < 64; i++) begin
        m_dm[i] = {rnd(), 16'd0} ^ rnd();
        m_im[i] = HALT;
      end
      for (int i = 0; i < 40; i++) begin
        int t, ra, rb, rc;
        logic [15:0] imm;
        t  = int'(rnd() % 9);
        ra = int'(rnd() % 8); rb = int'(rnd() % 8); rc = int'(rnd() % 8);
        imm = rnd();
        case (t)
          0: m_im[i] = rins(6'h20, rc, ra, rb);
          1: m_im[i] = rins(6'h22, rc, ra, rb);
          2: m_im[i] = rins(6'h24, rc, ra, rb);
          3: m_im[i] = rins(6'h25, rc, ra, rb);
          4: m_im[i] = rins(6'h2a, rc, ra, rb);
          5: m_im[i] = iins(6'h23, rc, ra, imm);
          6: m_im[i] = iins(6'h2b, rc, ra, imm);
          7: m_im[i] = iins(6'h04, rb % 4, ra % 4, {14'd0, imm[1:0]});
          default: m_im[i] = {6'h3E, ra[4:0], rb[4:0], imm};
        endcase
      end
      run(70);
      compare_regs("R11 generated program", 7);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule